// File: doc/BRIEF.md
# Table-Driven RAM Initialization Engine

This block prepares RAM contents from a compact list of records held in read-only memory. After a start strobe that carries the table's base address, it reads the list one byte at a time through a ROM port with one cycle of read latency. It writes the results through a RAM port addressed by an 8-bit page and an 8-bit offset. Each record names a RAM destination. The record then either supplies a run of bytes to copy or asks for a run of zeros. The walk ends at a terminator record, and the block reports this with a one-cycle done pulse.

Each record begins with a two-byte destination, page byte first. A third byte follows. If it is nonzero, it is a copy count and that many data bytes follow. If it is zero, the record is a clear record and one more byte gives the number of RAM bytes to set to zero. Records are packed back to back in ROM. The engine pulses a watchdog-service output each time it begins fetching a record. A long table therefore keeps a system watchdog satisfied while the walk runs.

Top module: `tbl_ram_init`

## Requirements
- R1: A record's first ROM byte is the RAM page and its second byte is the RAM offset. The record's first RAM write goes to exactly that page and offset.
- R2: A record whose first byte is 0xFF ends the walk with no RAM write. One cycle later `done_o` is high for exactly one cycle, and `busy_o` then returns low.
- R3: A nonzero third byte N (1 to 255) causes the next N ROM bytes to be written, in ROM order, to N consecutive RAM locations.
- R4: A third byte of 0x00 marks a clear record. The fourth byte M causes M consecutive RAM locations to be written with 0x00.
- R5: A clear record whose count M is 0x00 performs no RAM write. The next record is read from the byte right after M.
- R6: After a write at offset 0xFF, the next write of the same record goes to offset 0x00 of the next page. Page 0xFF is followed by page 0x00.
- R7: The first ROM read after an accepted start uses the base address. Each later read uses the previous read's address plus one. Read data is taken one cycle after `rom_rd_o`.
- R8: `wdog_kick_o` pulses once per record, the terminator included, in the cycle the record's first byte is requested.
- R9: A start strobe while `busy_o` is high has no effect on the walk in progress.
- R10: Out of reset the block is idle: `busy_o`, `done_o`, `ram_we_o`, `rom_rd_o` and `wdog_kick_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only while idle |
| base_addr_i | input | ADDR_W | ROM address of the first record |
| rom_rd_o | output | 1 | ROM read request |
| rom_addr_o | output | ADDR_W | ROM read address |
| rom_data_i | input | 8 | ROM data, valid the cycle after a request |
| ram_we_o | output | 1 | RAM write enable |
| ram_page_o | output | 8 | RAM write page |
| ram_off_o | output | 8 | RAM write offset within the page |
| ram_wdata_o | output | 8 | RAM write data |
| wdog_kick_o | output | 1 | Watchdog service pulse, one per record |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse after the terminator |

## Verification
The bench aims at the places where the record format branches. A zero third byte must switch to clear mode rather than copying zero bytes. A clear count of zero must write nothing and still advance. An engine that skipped the extra count byte would misread every following record as a wrong destination. Runs placed at offset 0xFE, and full 255-byte runs, cross a page boundary; a design that failed to carry into the page would overwrite the start of the same page. A second start fired mid-walk with a different base must not redirect the reads, and the watchdog pulse count is compared against the record count, terminator included.

// File: rtl/tbl_init_pkg.sv
package tbl_init_pkg;

    localparam int BYTE_W   = 8;
    localparam logic [BYTE_W-1:0] END_MARK = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAGE,
        ST_OFFS,
        ST_KIND,
        ST_CLRN,
        ST_COPY,
        ST_CLR,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        seq_state_e        state;
        logic              pend;
        logic [BYTE_W-1:0] cnt;
        logic [BYTE_W-1:0] page;
    } seq_reg_t;

endpackage

// File: rtl/tbl_init_rdaddr.sv
module tbl_init_rdaddr #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load_i) begin
            addr_d = base_i;
        end else if (step_i) begin
            addr_d = addr_q + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr_o = addr_q;
endmodule

// File: rtl/tbl_init_wrptr.sv
module tbl_init_wrptr #(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic              adv_i,
    output logic [PAGE_W-1:0] page_o,
    output logic [OFF_W-1:0]  off_o
);
    localparam int PTR_W = PAGE_W + OFF_W;

    logic [PTR_W-1:0] ptr_d, ptr_q;

    // The offset carry ripples into the page field; the page wraps naturally.
    always_comb begin
        ptr_d = ptr_q;
        if (load_i) begin
            ptr_d = {page_i, off_i};
        end else if (adv_i) begin
            ptr_d = ptr_q + PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign page_o = ptr_q[PTR_W-1:OFF_W];
    assign off_o  = ptr_q[OFF_W-1:0];
endmodule

// File: rtl/tbl_init_seq.sv
module tbl_init_seq
    import tbl_init_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic              addr_load_o,
    output logic              rd_o,
    output logic              ptr_load_o,
    output logic [BYTE_W-1:0] ptr_page_o,
    output logic [BYTE_W-1:0] ptr_off_o,
    output logic              wr_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              kick_o,
    output logic              busy_o,
    output logic              done_o
);
    seq_reg_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        addr_load_o = 1'b0;
        rd_o        = 1'b0;
        ptr_load_o  = 1'b0;
        ptr_page_o  = r_q.page;
        ptr_off_o   = rdata_i;
        wr_o        = 1'b0;
        wdata_o     = '0;
        kick_o      = 1'b0;
        done_o      = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    addr_load_o = 1'b1;
                    r_d.pend    = 1'b0;
                    r_d.state   = ST_PAGE;
                end
            end
            ST_PAGE: begin
                if (!r_q.pend) begin
                    rd_o     = 1'b1;
                    kick_o   = 1'b1;
                    r_d.pend = 1'b1;
                end else begin
                    r_d.pend = 1'b0;
                    if (rdata_i == END_MARK) begin
                        r_d.state = ST_FIN;
                    end else begin
                        r_d.page  = rdata_i;
                        r_d.state = ST_OFFS;
                    end
                end
            end
            ST_OFFS: begin
                if (!r_q.pend) begin
                    rd_o     = 1'b1;
                    r_d.pend = 1'b1;
                end else begin
                    r_d.pend   = 1'b0;
                    ptr_load_o = 1'b1;
                    r_d.state  = ST_KIND;
                end
            end
            ST_KIND: begin
                if (!r_q.pend) begin
                    rd_o     = 1'b1;
                    r_d.pend = 1'b1;
                end else begin
                    r_d.pend = 1'b0;
                    if (rdata_i != '0) begin
                        r_d.cnt   = rdata_i;
                        r_d.state = ST_COPY;
                    end else begin
                        r_d.state = ST_CLRN;
                    end
                end
            end
            ST_CLRN: begin
                if (!r_q.pend) begin
                    rd_o     = 1'b1;
                    r_d.pend = 1'b1;
                end else begin
                    r_d.pend = 1'b0;
                    if (rdata_i == '0) begin
                        r_d.state = ST_PAGE;
                    end else begin
                        r_d.cnt   = rdata_i;
                        r_d.state = ST_CLR;
                    end
                end
            end
            ST_COPY: begin
                if (!r_q.pend) begin
                    rd_o     = 1'b1;
                    r_d.pend = 1'b1;
                end else begin
                    r_d.pend = 1'b0;
                    wr_o     = 1'b1;
                    wdata_o  = rdata_i;
                    if (r_q.cnt == BYTE_W'(1)) begin
                        r_d.state = ST_PAGE;
                    end else begin
                        r_d.cnt = r_q.cnt - BYTE_W'(1);
                    end
                end
            end
            ST_CLR: begin
                wr_o = 1'b1;
                if (r_q.cnt == BYTE_W'(1)) begin
                    r_d.state = ST_PAGE;
                end else begin
                    r_d.cnt = r_q.cnt - BYTE_W'(1);
                end
            end
            ST_FIN: begin
                done_o    = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, pend: 1'b0, cnt: '0, page: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.state != ST_IDLE);
endmodule

// File: rtl/tbl_ram_init.sv
module tbl_ram_init
    import tbl_init_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic              rom_rd_o,
    output logic [ADDR_W-1:0] rom_addr_o,
    input  logic [7:0]        rom_data_i,
    output logic              ram_we_o,
    output logic [7:0]        ram_page_o,
    output logic [7:0]        ram_off_o,
    output logic [7:0]        ram_wdata_o,
    output logic              wdog_kick_o,
    output logic              busy_o,
    output logic              done_o
);
    logic              addr_load;
    logic              rd;
    logic              ptr_load;
    logic [BYTE_W-1:0] ptr_page;
    logic [BYTE_W-1:0] ptr_off;
    logic              wr;

    tbl_init_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .rdata_i     (rom_data_i),
        .addr_load_o (addr_load),
        .rd_o        (rd),
        .ptr_load_o  (ptr_load),
        .ptr_page_o  (ptr_page),
        .ptr_off_o   (ptr_off),
        .wr_o        (wr),
        .wdata_o     (ram_wdata_o),
        .kick_o      (wdog_kick_o),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    tbl_init_rdaddr #(.ADDR_W(ADDR_W)) u_rdaddr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (addr_load),
        .base_i (base_addr_i),
        .step_i (rd),
        .addr_o (rom_addr_o)
    );

    tbl_init_wrptr #(.PAGE_W(BYTE_W), .OFF_W(BYTE_W)) u_wrptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ptr_load),
        .page_i (ptr_page),
        .off_i  (ptr_off),
        .adv_i  (wr),
        .page_o (ram_page_o),
        .off_o  (ram_off_o)
    );

    assign rom_rd_o = rd;
    assign ram_we_o = wr;
endmodule

// File: rtl/tbl_ram_init_chk.sv
module tbl_ram_init_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              rom_rd_o,
    input logic [ADDR_W-1:0] rom_addr_o,
    input logic              ram_we_o,
    input logic [7:0]        ram_page_o,
    input logic [7:0]        ram_off_o,
    input logic              wdog_kick_o
);
    logic              have_rd_q;
    logic [ADDR_W-1:0] last_rd_q;
    logic              have_wr_q;
    logic [15:0]       last_wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_rd_q <= 1'b0;
            last_rd_q <= '0;
            have_wr_q <= 1'b0;
            last_wr_q <= '0;
        end else begin
            if (start_i && !busy_o) begin
                have_rd_q <= 1'b0;
            end else if (rom_rd_o) begin
                have_rd_q <= 1'b1;
                last_rd_q <= rom_addr_o;
            end
            if (wdog_kick_o) begin
                have_wr_q <= 1'b0;
            end else if (ram_we_o) begin
                have_wr_q <= 1'b1;
                last_wr_q <= {ram_page_o, ram_off_o};
            end
        end
    end

    p_rom_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd_o && have_rd_q) |-> (rom_addr_o == last_rd_q + ADDR_W'(1)));

    p_page_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we_o && have_wr_q) |-> ({ram_page_o, ram_off_o} == last_wr_q + 16'd1));

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !ram_we_o);

    p_kick_on_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_kick_o |-> (rom_rd_o && busy_o));

    p_write_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we_o || rom_rd_o) |-> busy_o);

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o);
endmodule

bind tbl_ram_init tbl_ram_init_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rom_rd_o    (rom_rd_o),
    .rom_addr_o  (rom_addr_o),
    .ram_we_o    (ram_we_o),
    .ram_page_o  (ram_page_o),
    .ram_off_o   (ram_off_o),
    .wdog_kick_o (wdog_kick_o)
);

// File: tb/tbl_ram_init_tb_top.sv
`timescale 1ns/1ps
module tbl_ram_init_tb_top;
    localparam int AW    = 12;
    localparam int ROM_N = 1 << AW;
    localparam int EXP_N = 2048;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_addr_i = '0;
    logic          rom_rd_o;
    logic [AW-1:0] rom_addr_o;
    logic [7:0]    rom_data_i = '0;
    logic          ram_we_o;
    logic [7:0]    ram_page_o, ram_off_o, ram_wdata_o;
    logic          wdog_kick_o, busy_o, done_o;

    always #2.5 clk = ~clk;

    tbl_ram_init #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_addr_i(base_addr_i),
        .rom_rd_o(rom_rd_o), .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i),
        .ram_we_o(ram_we_o), .ram_page_o(ram_page_o), .ram_off_o(ram_off_o),
        .ram_wdata_o(ram_wdata_o), .wdog_kick_o(wdog_kick_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    logic [7:0]  rom_mem [0:ROM_N-1];
    logic [23:0] exp_wr  [0:EXP_N-1];
    logic [23:0] act_wr  [0:EXP_N-1];
    int exp_n, exp_kicks, act_n, kicks, dones, wp;
    int checks = 0, errors = 0;
    int cycles = 0;
    bit mon_en = 1'b0;

    // ROM model: data valid one cycle after the request
    always @(posedge clk) if (rom_rd_o) rom_data_i <= rom_mem[rom_addr_o];

    always @(negedge clk) begin
        cycles++;
        if (mon_en) begin
            if (ram_we_o) begin
                if (act_n < EXP_N) act_wr[act_n] = {ram_page_o, ram_off_o, ram_wdata_o};
                act_n++;
            end
            if (wdog_kick_o) kicks++;
            if (done_o) dones++;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        rom_mem[wp] = b;
        wp++;
    endtask

    task automatic rec_copy(input logic [7:0] pg, input logic [7:0] of, input int n);
        put(pg); put(of); put(8'(n));
        for (int i = 0; i < n; i++) put(8'($urandom));
    endtask

    task automatic rec_clear(input logic [7:0] pg, input logic [7:0] of, input int n);
        put(pg); put(of); put(8'h00); put(8'(n));
    endtask

    task automatic rec_end();
        put(8'hFF);
    endtask

    // Reference walk of the record format
    task automatic model(input int base);
        int a;
        logic [15:0] dst;
        logic [7:0] hi, kind, n;
        a = base; exp_n = 0; exp_kicks = 0;
        while (1) begin
            exp_kicks++;
            hi = rom_mem[a]; a++;
            if (hi == 8'hFF) break;
            dst = {hi, rom_mem[a]}; a++;
            kind = rom_mem[a]; a++;
            if (kind != 0) begin
                for (int i = 0; i < int'(kind); i++) begin
                    exp_wr[exp_n] = {dst, rom_mem[a]}; exp_n++; a++; dst++;
                end
            end else begin
                n = rom_mem[a]; a++;
                for (int i = 0; i < int'(n); i++) begin
                    exp_wr[exp_n] = {dst, 8'h00}; exp_n++; dst++;
                end
            end
        end
    endtask

    task automatic run(input int base, input bit poke, input string tag);
        int t, bad, first;
        model(base);
        act_n = 0; kicks = 0; dones = 0; mon_en = 1'b1;
        @(negedge clk); start_i = 1'b1; base_addr_i = AW'(base);
        @(negedge clk); start_i = 1'b0;
        if (poke) begin
            repeat (7) @(negedge clk);
            start_i = 1'b1; base_addr_i = '0;
            @(negedge clk); start_i = 1'b0;
        end
        t = 0;
        while (dones == 0 && t < 20000) begin @(negedge clk); t++; end
        repeat (2) @(negedge clk);
        mon_en = 1'b0;
        chk(t < 20000, {tag, " R2 walk ends"}, t, 0);
        chk(dones == 1, {tag, " R2 done one cycle"}, dones, 1);
        chk(!busy_o, {tag, " R2 idle after done"}, busy_o, 0);
        chk(kicks == exp_kicks, {tag, " R8 kick count"}, kicks, exp_kicks);
        chk(act_n == exp_n, {tag, " write count"}, act_n, exp_n);
        bad = 0; first = -1;
        for (int i = 0; i < exp_n && i < act_n; i++)
            if (act_wr[i] !== exp_wr[i]) begin bad++; if (first < 0) first = i; end
        chk(bad == 0, {tag, " write list"}, (first < 0) ? 0 : act_wr[first],
            (first < 0) ? 0 : exp_wr[first]);
    endtask

    initial begin : watchdog
        wait (cycles > 150000);
        chk(1'b0, "watchdog expired", cycles, 150000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < ROM_N; i++) rom_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!busy_o && !done_o && !ram_we_o && !rom_rd_o && !wdog_kick_o,
            "R10 reset idle", {busy_o, done_o, ram_we_o, rom_rd_o, wdog_kick_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_o && !ram_we_o, "R10 idle after reset", busy_o, 0);

        // R2: immediate terminator
        wp = 0; rec_end();
        run(0, 1'b0, "R2 empty");

        // R1 R3: single copy record
        wp = 16; rec_copy(8'h03, 8'h40, 3); rec_end();
        run(16, 1'b0, "R1 R3 copy");

        // R4 and R5: clear records, one of zero length
        wp = 64; rec_clear(8'h05, 8'h10, 5); rec_clear(8'h06, 8'h00, 0);
        rec_copy(8'h07, 8'h01, 2); rec_end();
        run(64, 1'b0, "R4 R5 clear");

        // R6: page carry on copy and clear, including page 0xFF to 0x00
        wp = 128; rec_copy(8'h12, 8'hFE, 4); rec_clear(8'hFF, 8'hF0, 255);
        rec_copy(8'h20, 8'h01, 255); rec_end();
        run(128, 1'b0, "R6 wrap");

        // R9: second start mid-walk must not redirect; R7 nonzero base
        wp = 1200; rec_copy(8'h30, 8'h80, 6); rec_clear(8'h31, 8'hFD, 7); rec_end();
        rom_mem[0] = 8'h44;
        run(1200, 1'b1, "R9 R7 busy start");
        rom_mem[0] = 8'hFF;

        // R1 R3 R4 R5 R6 R7 R8: random tables
        for (int k = 0; k < 20; k++) begin
            int base, nrec;
            base = 2 + int'($urandom_range(400));
            wp = base;
            nrec = 1 + int'($urandom_range(5));
            for (int r = 0; r < nrec; r++) begin
                logic [7:0] pg, of;
                int n, sel;
                pg = 8'($urandom_range(254));
                of = 8'($urandom);
                sel = int'($urandom_range(9));
                n = (sel == 0) ? 255 : (sel == 1) ? 0 : (sel == 2) ? 1 : int'($urandom_range(60));
                if ($urandom_range(1) == 0 && n != 0) rec_copy(pg, of, n);
                else rec_clear(pg, of, n);
            end
            rec_end();
            run(base, k[0], "R7 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule